// File: doc/BRIEF.md
# Paged Data Address Translator

This block maps a 16-bit logical data address onto a 24-bit physical address. There are four page pointer registers. The two most significant address bits choose one of them. Ten bits of the chosen pointer become the top of the physical address, and the remaining fourteen address bits pass through unchanged as the offset within the page.

A request can also override the pointer registers for a single access. In page mode, a page number that arrives with the request takes the place of the pointer. In segment mode, an 8-bit segment that arrives with the request is placed above the whole 16-bit address.

A word access at an odd byte address is not translated. For such a request the valid strobe stays low, and a trap pulse appears one cycle later. The pointers are loaded and read back through a small register port. After reset, every logical address maps to the same physical address inside the lowest 64 KB.

Top module: `dseg_xlate`

## Requirements
- R1: After reset the pointers hold 0, 1, 2 and 3 (pointer n holds n). A pointer-mode request therefore yields a physical address equal to the logical address with the upper 8 bits zero.
- R2: For a request with `req_mode` = 0, `req_addr[15:14]` selects pointer n, and `phys_addr` = {pointer n[9:0], `req_addr[13:0]`}.
- R3: A write with `wr_en` = 1 loads `wr_data[9:0]` into the pointer named by `wr_sel`, and `wr_data[15:10]` is ignored. `rd_data` returns the pointer named by `rd_sel` in bits 9:0, with zeros in bits 15:10.
- R4: If a pointer write and a request occur in the same cycle, the request is translated with the old pointer value. The new value is used from the next cycle onward.
- R5: With `req_mode` = 1 (page override), `phys_addr` = {`req_page[9:0]`, `req_addr[13:0]`}, whatever the pointers hold.
- R6: With `req_mode` = 2 (segment override), `phys_addr` = {`req_seg[7:0]`, `req_addr[15:0]`}.
- R7: `req_mode` = 3 is reserved and translates exactly as `req_mode` = 0.
- R8: A request with `req_word` = 1 and `req_addr[0]` = 1 is misaligned. In its cycle, `phys_vld` = 0 and `phys_addr` = 0. A byte request (`req_word` = 0) is never misaligned.
- R9: `trap` is high for exactly the one clock cycle that follows a misaligned request, and it is low after every other cycle.
- R10: The translation is combinational. `phys_vld` equals `req_vld` in the same cycle for aligned requests, and while `phys_vld` = 0, `phys_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Pointer write enable |
| wr_sel | input | 2 | Index of the pointer to write |
| wr_data | input | 16 | Write data; only bits 9:0 are stored |
| rd_sel | input | 2 | Index of the pointer to read |
| rd_data | output | 16 | Value of the selected pointer, zero-extended |
| req_vld | input | 1 | Translation request present |
| req_addr | input | 16 | Logical address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_mode | input | 2 | 0 pointer, 1 page override, 2 segment override, 3 reserved (acts as 0) |
| req_page | input | 10 | Page number used in page-override mode |
| req_seg | input | 8 | Segment used in segment-override mode |
| phys_addr | output | 24 | Physical address, zero when not valid |
| phys_vld | output | 1 | Physical address valid in this cycle |
| trap | output | 1 | One-cycle pulse after a misaligned word request |

## Verification
A wrong pointer value appears at the ports in the same cycle as any pointer-mode request whose top address bits select that pointer. It also appears on `rd_data` as soon as `rd_sel` names that pointer. The bench therefore loads distinct values into every pointer, with junk in the ignored upper bits, and sweeps address patterns across all four pages, every mode and both access sizes. A fault in the trap register shows one cycle after the request, so every request is also followed by a trap check. A write and a request are issued in the same cycle to confirm that the old pointer value is used.

// File: rtl/dseg_pkg.sv
package dseg_pkg;

  typedef enum logic [1:0] {
    XM_PTR  = 2'd0,
    XM_PAGE = 2'd1,
    XM_SEG  = 2'd2,
    XM_RSV  = 2'd3
  } xmode_e;

endpackage

// File: rtl/dseg_rst_sync.sv
module dseg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/dseg_ptr_bank.sv
module dseg_ptr_bank #(
  parameter int NPTR   = 4,
  parameter int PAGE_W = 10,
  parameter int DATA_W = 16,
  localparam int SEL_W = $clog2(NPTR)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [SEL_W-1:0]             rd_sel,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NPTR-1:0][PAGE_W-1:0]  ptrs
);

  logic [NPTR-1:0][PAGE_W-1:0] ptr_q;
  logic [NPTR-1:0][PAGE_W-1:0] ptr_d;
  logic [NPTR-1:0]             ptr_ce;

  // Per-register enable and next value
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_comb begin
      ptr_ce[g] = wr_en && (wr_sel == SEL_W'(g));
      ptr_d[g]  = wr_data[PAGE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptr_q[g] <= PAGE_W'(g);
      else if (ptr_ce[g]) ptr_q[g] <= ptr_d[g];
    end
  end

  assign ptrs    = ptr_q;
  assign rd_data = {{(DATA_W-PAGE_W){1'b0}}, ptr_q[rd_sel]};

  // R3: a write lands in the addressed pointer on the next cycle
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr_q[$past(wr_sel)] == $past(wr_data[PAGE_W-1:0]));

  // R4: an unwritten pointer keeps its value
  a_r4_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr_q));

endmodule

// File: rtl/dseg_addr_map.sv
module dseg_addr_map
  import dseg_pkg::*;
#(
  parameter int NPTR    = 4,
  parameter int PAGE_W  = 10,
  parameter int LADDR_W = 16,
  parameter int SEG_W   = 8,
  localparam int SEL_W   = $clog2(NPTR),
  localparam int OFS_W   = LADDR_W - SEL_W,
  localparam int PADDR_W = PAGE_W + OFS_W
) (
  input  logic [NPTR-1:0][PAGE_W-1:0] ptrs,
  input  logic                        req_vld,
  input  logic [LADDR_W-1:0]          req_addr,
  input  logic                        req_word,
  input  xmode_e                      req_mode,
  input  logic [PAGE_W-1:0]           req_page,
  input  logic [SEG_W-1:0]            req_seg,
  output logic [PADDR_W-1:0]          phys_addr,
  output logic                        phys_vld,
  output logic                        misal
);

  logic [SEL_W-1:0]   sel;
  logic [OFS_W-1:0]   ofs;
  logic [PADDR_W-1:0] pa_raw;

  always_comb begin
    sel   = req_addr[LADDR_W-1 -: SEL_W];
    ofs   = req_addr[OFS_W-1:0];
    misal = req_word && req_addr[0];
    unique case (req_mode)
      XM_PAGE: pa_raw = {req_page, ofs};
      XM_SEG:  pa_raw = PADDR_W'({req_seg, req_addr});
      default: pa_raw = {ptrs[sel], ofs};
    endcase
    phys_vld  = req_vld && !misal;
    phys_addr = phys_vld ? pa_raw : '0;
  end

endmodule

// File: rtl/dseg_trap_gen.sv
module dseg_trap_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic req_vld,
  input  logic misal,
  output logic trap
);

  logic trap_d;
  logic trap_q;

  always_comb begin
    trap_d = req_vld && misal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  assign trap = trap_q;

endmodule

// File: rtl/dseg_xlate.sv
module dseg_xlate
  import dseg_pkg::*;
#(
  parameter int NPTR    = 4,
  parameter int PAGE_W  = 10,
  parameter int LADDR_W = 16,
  parameter int SEG_W   = 8,
  parameter int DATA_W  = 16,
  localparam int SEL_W   = $clog2(NPTR),
  localparam int OFS_W   = LADDR_W - SEL_W,
  localparam int PADDR_W = PAGE_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               req_vld,
  input  logic [LADDR_W-1:0] req_addr,
  input  logic               req_word,
  input  logic [1:0]         req_mode,
  input  logic [PAGE_W-1:0]  req_page,
  input  logic [SEG_W-1:0]   req_seg,
  output logic [PADDR_W-1:0] phys_addr,
  output logic               phys_vld,
  output logic               trap
);

  logic                        rst_sync_n;
  logic [NPTR-1:0][PAGE_W-1:0] ptrs;
  logic                        misal;
  xmode_e                      mode;

  assign mode = xmode_e'(req_mode);

  dseg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dseg_ptr_bank #(
    .NPTR   (NPTR),
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .ptrs    (ptrs)
  );

  dseg_addr_map #(
    .NPTR    (NPTR),
    .PAGE_W  (PAGE_W),
    .LADDR_W (LADDR_W),
    .SEG_W   (SEG_W)
  ) u_map (
    .ptrs      (ptrs),
    .req_vld   (req_vld),
    .req_addr  (req_addr),
    .req_word  (req_word),
    .req_mode  (mode),
    .req_page  (req_page),
    .req_seg   (req_seg),
    .phys_addr (phys_addr),
    .phys_vld  (phys_vld),
    .misal     (misal)
  );

  dseg_trap_gen u_trap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req_vld (req_vld),
    .misal   (misal),
    .trap    (trap)
  );

  // R8: no valid address for a misaligned word access
  a_r8_no_vld_misal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phys_vld |-> !(req_word && req_addr[0]));

  // R9: a trap pulse follows only a misaligned request
  a_r9_trap_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap |-> $past(req_vld && req_word && req_addr[0]));

  // R2: the page offset passes through unchanged in pointer and page modes
  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phys_vld && req_mode != 2'd2) |-> phys_addr[OFS_W-1:0] == req_addr[OFS_W-1:0]);

  // R6: segment mode keeps the full logical address
  a_r6_seg_join: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phys_vld && req_mode == 2'd2) |-> phys_addr == PADDR_W'({req_seg, req_addr}));

  // R3: the unused read bits are zero
  a_r3_rd_upper_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data[DATA_W-1:PAGE_W] == '0);

  // R10: nothing is issued without a request
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_vld |-> (!phys_vld && phys_addr == '0));

endmodule

// File: tb/sim_dseg_xlate.sv
`timescale 1ns/1ps
module sim_dseg_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        req_vld = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic [1:0]  req_mode = '0;
  logic [9:0]  req_page = '0;
  logic [7:0]  req_seg = '0;
  logic [23:0] phys_addr;
  logic        phys_vld;
  logic        trap;

  int n_vec = 0;
  int n_bad = 0;
  logic [9:0] mdl [4];

  always #4 clk = ~clk;

  dseg_xlate u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .req_vld(req_vld), .req_addr(req_addr), .req_word(req_word),
    .req_mode(req_mode), .req_page(req_page), .req_seg(req_seg),
    .phys_addr(phys_addr), .phys_vld(phys_vld), .trap(trap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_pa(input logic v, input logic [15:0] a,
                                           input logic w, input logic [1:0] m,
                                           input logic [9:0] pg, input logic [7:0] sg);
    if (!v || (w && a[0])) return 24'h0;
    case (m)
      2'd1:    return {pg, a[13:0]};
      2'd2:    return {sg, a};
      default: return {mdl[a[15:14]], a[13:0]};
    endcase
  endfunction

  // Issue one request; check the combinational outputs, then the trap a cycle later
  task automatic apply(input logic v, input logic [15:0] a, input logic w,
                       input logic [1:0] m, input logic [9:0] pg, input logic [7:0] sg,
                       input string tag);
    logic misl;
    @(negedge clk);
    req_vld = v; req_addr = a; req_word = w; req_mode = m; req_page = pg; req_seg = sg;
    #2;
    misl = v && w && a[0];
    chk({tag, " addr"}, {8'h0, phys_addr}, {8'h0, model_pa(v, a, w, m, pg, sg)});
    chk({tag, " R10 vld"}, {31'h0, phys_vld}, {31'h0, v && !misl});
    @(posedge clk); #1;
    chk({tag, " R9 trap"}, {31'h0, trap}, {31'h0, misl});
  endtask

  task automatic wr_ptr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    mdl[s] = d[9:0];
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) mdl[k] = 10'(k);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset contents and identity map
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); rd_sel = 2'(k); #1;
      chk("R1 reset ptr", {16'h0, rd_data}, 32'(k));
    end
    chk("R9 trap idle after reset", {31'h0, trap}, 32'h0);
    for (int i = 0; i < 64; i++) begin
      logic [15:0] a;
      a = 16'(i * 16'h0403 + 1);
      apply(1'b1, a, 1'b0, 2'd0, 10'h0, 8'h0, "R1 identity");
      chk("R1 identity value", {8'h0, phys_addr}, 32'(a));
    end

    // R3: load pointers with junk in upper bits, read back
    for (int k = 0; k < 4; k++)
      wr_ptr(2'(k), {6'h2A ^ 6'(k), 10'((k * 10'h1A5) + 10'h2B3)});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); rd_sel = 2'(k); #1;
      chk("R3 readback", {16'h0, rd_data}, {22'h0, mdl[k]});
    end

    // R2/R5/R6/R7/R8/R9/R10: sweep addresses, modes, sizes, valid
    for (int i = 0; i < 4096; i++) begin
      logic [15:0] a;
      a = 16'((i << 4) ^ (i & 15) ^ (i >> 7));
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 2; w++)
          apply(1'b1, a, w[0], 2'(m), 10'(i * 7), 8'(i * 13), "R2/R5/R6/R7/R8 sweep");
      if ((i & 63) == 0)
        apply(1'b0, a, 1'b0, 2'(i >> 6), 10'h3FF, 8'hFF, "R10 idle");
    end

    // R4: write and translate in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'hFC55;
    req_vld = 1'b1; req_addr = 16'h8ABC; req_word = 1'b0; req_mode = 2'd0;
    #2;
    chk("R4 old value", {8'h0, phys_addr}, {8'h0, mdl[2], 14'h0ABC});
    @(posedge clk); #1;
    wr_en = 1'b0; mdl[2] = 10'h055;
    @(negedge clk); #2;
    chk("R4 new value", {8'h0, phys_addr}, {8'h0, 10'h055, 14'h0ABC});
    rd_sel = 2'd2; #1;
    chk("R3 upper ignored", {16'h0, rd_data}, 32'h0055);

    // R8/R9: back-to-back misaligned words give back-to-back pulses
    apply(1'b1, 16'h1235, 1'b1, 2'd0, 10'h0, 8'h0, "R8 misal a");
    apply(1'b1, 16'h4237, 1'b1, 2'd2, 10'h0, 8'h12, "R8 misal b");
    apply(1'b1, 16'h4237, 1'b0, 2'd2, 10'h0, 8'h12, "R8 byte odd");
    apply(1'b0, 16'h0000, 1'b0, 2'd0, 10'h0, 8'h0, "R9 quiet");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule